// File: doc/BRIEF.md
# Multi-Mode Load Modulation Encoder

This block turns a serial identification bit stream into the on/off control of a damping load. It runs directly on the recovered carrier clock. Four line codes can be selected: phase-shift keying on a half-rate subcarrier, a biphase code, Manchester, and a biphase code that steers a two-tone frequency-shift subcarrier. An upstream bit-rate divider pulses `bit_stb` for one carrier cycle at the start of every bit period. The encoder places every edge of the output relative to that pulse.

Data enters on a valid/ready pair. `din_ready` is high only in the strobe cycle, because the bit clock sets the pace and the encoder cannot wait. A bit transfers when `din_valid` and `din_ready` are both high. The producer cannot delay a boundary: if no bit is offered at a strobe, the encoder sends a 0 for that period. The mode select is a plain control input. It is read only at strobes, so a bit period is always coded in one mode from start to finish.

Top module: `load_mod_enc`

## Requirements
- R1: While `rst` is high at a clock edge, `load_on` is 0 after that edge. The PSK phase reference starts at 0 degrees, the current bit at 0 and the mode at PSK.
- R2: `din_ready` equals `bit_stb` in every cycle. A bit is taken only at a strobe edge with `din_valid` high.
- R3: If `din_valid` is low at a strobe, that bit period is coded as data 0, whatever the value of `din`.
- R4: In PSK mode (`mode_sel` = 0), `load_on` toggles on every carrier edge that is not a strobe edge, which gives a subcarrier of carrier/2.
- R5: In PSK mode, at the strobe edge that ends a data 1 bit, `load_on` holds its level (a 180 degree phase shift). At the edge that ends a data 0 bit, it toggles as usual.
- R6: In biphase mode (`mode_sel` = 1), `load_on` toggles at every strobe edge.
- R7: In biphase mode, `load_on` also toggles BIT_LEN/2 cycles after the strobe edge when the bit is 1, and stays steady when the bit is 0.
- R8: In Manchester mode (`mode_sel` = 2), the first half of the bit is the inverse of the bit and the second half is the bit. This gives a rising mid-bit edge for a 1 and a falling one for a 0.
- R9: In biphase-FSK mode (`mode_sel` = 3), the output is a subcarrier. Its half period is 4 carrier cycles (carrier/8) while the biphase level is 0 and 5 cycles (carrier/10) while it is 1. The biphase level follows the rules of R6 and R7.
- R10: `mode_sel` is sampled only at strobe edges. Changing it in any other cycle has no effect on `load_on`.
- R11: A mid-bit event happens only once, BIT_LEN/2 cycles after a strobe. If the next strobe is late, no further mid-bit events occur until it arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered carrier clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Line code: 0 PSK, 1 biphase, 2 Manchester, 3 biphase-FSK |
| bit_stb | input | 1 | One-cycle pulse at the start of each bit period |
| din | input | 1 | Serial data bit |
| din_valid | input | 1 | A bit is offered on `din` |
| din_ready | output | 1 | The encoder takes a bit this cycle |
| load_on | output | 1 | Damping load control |

## Verification
Every output is driven by a register one carrier edge deep. A bit, mode or reset sampled at an edge is therefore visible on `load_on` right after that edge. The Manchester and biphase mid-bit edges are due exactly BIT_LEN/2 edges after the strobe edge. `din_ready` is combinational from the strobe and valid in the same cycle. The bench drives inputs on the falling edge and updates its reference at the rising edge. It compares both outputs at the next falling edge, one per cycle, so every result is checked in the cycle it falls due, with no tolerance window.

// File: rtl/lme_pkg.sv
package lme_pkg;
  typedef enum logic [1:0] {
    MODE_PSK  = 2'd0,
    MODE_BIPH = 2'd1,
    MODE_MAN  = 2'd2,
    MODE_BFSK = 2'd3
  } mode_e;
endpackage

// File: rtl/lme_bit_timer.sv
module lme_bit_timer #(
  parameter int BIT_LEN = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  output logic mid_evt
);
  localparam int PW = $clog2(BIT_LEN);
  localparam logic [PW-1:0] LAST   = PW'(BIT_LEN - 1);
  localparam logic [PW-1:0] MID_AT = PW'(BIT_LEN / 2 - 1);

  logic [PW-1:0] pos;

  // Saturating position inside the bit; parked at LAST until a strobe arrives
  always_ff @(posedge clk) begin
    if (rst)              pos <= LAST;
    else if (bit_stb)     pos <= '0;
    else if (pos != LAST) pos <= pos + 1'b1;
  end

  assign mid_evt = !bit_stb && (pos == MID_AT);
endmodule

// File: rtl/lme_psk.sv
module lme_psk (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic psk_q
);
  logic half;
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      half  <= 1'b0;
      phase <= 1'b0;
    end else begin
      half  <= ~half;
      if (flip) phase <= ~phase;
    end
  end

  assign psk_q = half ^ phase;
endmodule

// File: rtl/lme_line_codes.sv
module lme_line_codes (
  input  logic clk,
  input  logic rst,
  input  logic bound,
  input  logic mid,
  input  logic new_bit,
  input  logic cur_bit,
  output logic biph_q,
  output logic man_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      biph_q <= 1'b0;
      man_q  <= 1'b0;
    end else begin
      if (bound)              biph_q <= ~biph_q;
      else if (mid && cur_bit) biph_q <= ~biph_q;

      if (bound)     man_q <= ~new_bit;
      else if (mid)  man_q <= cur_bit;
    end
  end
endmodule

// File: rtl/lme_fsk.sv
module lme_fsk #(
  parameter int HALF_LO = 4,
  parameter int HALF_HI = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_hi,
  output logic fsk_q
);
  localparam int FW = $clog2(HALF_HI + 1);
  localparam logic [FW-1:0] END_LO = FW'(HALF_LO - 1);
  localparam logic [FW-1:0] END_HI = FW'(HALF_HI - 1);

  logic [FW-1:0] cnt;
  logic [FW-1:0] cnt_end;

  assign cnt_end = sel_hi ? END_HI : END_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fsk_q <= 1'b0;
    end else if (cnt >= cnt_end) begin
      cnt   <= '0;
      fsk_q <= ~fsk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/load_mod_enc.sv
module load_mod_enc #(
  parameter int BIT_LEN  = 40,
  parameter int FSK_LO_H = 4,
  parameter int FSK_HI_H = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       bit_stb,
  input  logic       din,
  input  logic       din_valid,
  output logic       din_ready,
  output logic       load_on
);
  import lme_pkg::*;

  mode_e mode_r;
  logic  cur_bit;
  logic  new_bit;
  logic  mid_evt;
  logic  psk_q, biph_q, man_q, fsk_q;

  assign din_ready = bit_stb;
  assign new_bit   = bit_stb && din_valid && din;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r  <= MODE_PSK;
      cur_bit <= 1'b0;
    end else if (bit_stb) begin
      mode_r  <= mode_e'(mode_sel);
      cur_bit <= new_bit;
    end
  end

  lme_bit_timer #(.BIT_LEN(BIT_LEN)) u_timer (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .mid_evt(mid_evt)
  );

  lme_psk u_psk (
    .clk(clk), .rst(rst),
    .flip(bit_stb && (mode_r == MODE_PSK) && cur_bit),
    .psk_q(psk_q)
  );

  lme_line_codes u_codes (
    .clk(clk), .rst(rst), .bound(bit_stb), .mid(mid_evt),
    .new_bit(new_bit), .cur_bit(cur_bit),
    .biph_q(biph_q), .man_q(man_q)
  );

  lme_fsk #(.HALF_LO(FSK_LO_H), .HALF_HI(FSK_HI_H)) u_fsk (
    .clk(clk), .rst(rst), .sel_hi(biph_q), .fsk_q(fsk_q)
  );

  always_comb begin
    unique case (mode_r)
      MODE_PSK:  load_on = psk_q;
      MODE_BIPH: load_on = biph_q;
      MODE_MAN:  load_on = man_q;
      default:   load_on = fsk_q;
    endcase
  end
endmodule

// File: rtl/lme_chk.sv
module lme_chk (
  input logic           clk,
  input logic           rst,
  input logic           bit_stb,
  input logic [1:0]     mode_sel,
  input logic           load_on,
  input lme_pkg::mode_e mode_r,
  input logic           cur_bit,
  input logic           mid_evt
);
  import lme_pkg::*;

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !load_on);

  // R4
  psk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MODE_PSK && !bit_stb) |=> (load_on != $past(load_on)));

  // R5
  psk_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MODE_PSK && mode_sel == 2'd0 && bit_stb && cur_bit) |=> $stable(load_on));

  // R6
  biph_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MODE_BIPH && mode_sel == 2'd1 && bit_stb) |=> (load_on != $past(load_on)));

  // R7
  biph_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MODE_BIPH && mid_evt && !cur_bit) |=> $stable(load_on));

  // R8
  man_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MODE_MAN && mid_evt) |=> (load_on == $past(cur_bit)));
endmodule

bind load_mod_enc lme_chk u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .mode_sel(mode_sel),
  .load_on(load_on), .mode_r(mode_r), .cur_bit(cur_bit), .mid_evt(mid_evt)
);

// File: tb/load_mod_enc_tb.sv
`timescale 1ns/1ps
module load_mod_enc_tb;
  localparam int BL   = 40;
  localparam int HALF = BL / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic       bit_stb = 1'b0;
  logic       din = 1'b0;
  logic       din_valid = 1'b0;
  logic       din_ready;
  logic       load_on;

  int n_chk = 0;
  int n_bad = 0;
  string phase_tag = "R1";

  always #2.5 clk = ~clk;

  load_mod_enc u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .bit_stb(bit_stb),
    .din(din), .din_valid(din_valid), .din_ready(din_ready), .load_on(load_on)
  );

  // Reference model
  int m_pos = BL - 1, m_mode = 0, m_fc = 0;
  bit m_cur = 0, m_t = 0, m_ph = 0, m_bl = 0, m_man = 0, m_s = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = BL - 1; m_mode = 0; m_fc = 0;
      m_cur = 0; m_t = 0; m_ph = 0; m_bl = 0; m_man = 0; m_s = 0;
    end else begin
      bit mid, nb;
      int hp;
      mid = !bit_stb && (m_pos == HALF - 1);
      nb  = bit_stb && din_valid && din;
      m_t = !m_t;
      if (bit_stb && m_mode == 0 && m_cur) m_ph = !m_ph;
      hp = m_bl ? 5 : 4;
      if (m_fc >= hp - 1) begin m_fc = 0; m_s = !m_s; end
      else m_fc++;
      if (bit_stb) m_bl = !m_bl;
      else if (mid && m_cur) m_bl = !m_bl;
      if (bit_stb) m_man = !nb;
      else if (mid) m_man = m_cur;
      if (bit_stb) m_pos = 0;
      else if (m_pos < BL - 1) m_pos++;
      if (bit_stb) begin m_cur = nb; m_mode = int'(mode_sel); end
    end
  end

  function automatic bit m_out();
    case (m_mode)
      0: return m_t ^ m_ph;
      1: return m_bl;
      2: return m_man;
      default: return m_s;
    endcase
  endfunction

  function automatic string mode_tag();
    case (m_mode)
      0: return "R4 R5";
      1: return "R6 R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Compare current outputs, then drive the next cycle's inputs
  task automatic step(input bit stb, input int md, input bit d, input bit v);
    @(negedge clk);
    chk(load_on == m_out(), {mode_tag(), " ", phase_tag}, int'(load_on), int'(m_out()));
    chk(din_ready == bit_stb, "R2 ready", int'(din_ready), int'(bit_stb));
    bit_stb   = stb;
    mode_sel  = 2'(md);
    din       = d;
    din_valid = v;
  endtask

  // One bit period; mode_sel and din are scrambled between strobes (R10)
  task automatic send_bit(input int md, input bit d, input bit v, input int len);
    step(1'b1, md, d, v);
    for (int i = 1; i < len; i++) step(1'b0, 3 - md, ~d, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(load_on == 1'b0, "R1 reset", int'(load_on), 0);
    rst = 1'b0;
    phase_tag = "R4 idle";
    for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b0, 1'b0);

    phase_tag = "R5 psk";
    begin
      bit p[6] = '{1, 0, 1, 1, 0, 1};
      foreach (p[i]) send_bit(0, p[i], 1'b1, BL);
    end
    phase_tag = "R7 biphase";
    begin
      bit p[6] = '{1, 0, 0, 1, 1, 0};
      foreach (p[i]) send_bit(1, p[i], 1'b1, BL);
    end
    phase_tag = "R8 manchester";
    begin
      bit p[6] = '{1, 0, 1, 1, 0, 0};
      foreach (p[i]) send_bit(2, p[i], 1'b1, BL);
    end
    phase_tag = "R3 no-valid";
    send_bit(2, 1'b1, 1'b0, BL);
    send_bit(1, 1'b1, 1'b0, BL);
    phase_tag = "R9 fsk";
    begin
      bit p[7] = '{0, 0, 1, 1, 0, 1, 0};
      foreach (p[i]) send_bit(3, p[i], 1'b1, BL);
    end
    phase_tag = "R11 late strobe";
    send_bit(1, 1'b1, 1'b1, 3 * BL);
    send_bit(2, 1'b0, 1'b1, 2 * BL);
    phase_tag = "R10 mode switch";
    send_bit(0, 1'b1, 1'b1, BL);
    send_bit(3, 1'b1, 1'b1, BL);
    send_bit(0, 1'b1, 1'b1, BL);
    send_bit(2, 1'b1, 1'b1, BL);
    step(1'b0, 0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule